// File: doc/BRIEF.md
# Byte Staging FIFO with Fill-Threshold Interrupt Status

This block is the byte buffer that sits between a host register interface and a serial transfer engine. Both sides share one small first-in first-out store. The host writes bytes into it and reads bytes out through a single data register, and it can read the fill count from a pointer register. The engine uses a plain push/pop strobe interface. Writing zero to the pointer register empties the store. A transfer-start pulse from the engine also empties it, unless an option bit asks for the contents to be kept. Keeping the contents lets the host preload bytes for a full-duplex exchange.

A two-bit threshold code selects 1, 2, 4 or 8 bytes. Two sticky status flags follow that threshold. One says enough bytes are waiting to be read. The other says enough free space exists to be written. Three further sticky flags record engine events: transfer finished, frame received and frame sent. An enable register masks the flags, and a single interrupt line is the OR of the enabled flags.

Top module: `byte_fifo_ctl`

## Requirements
- R1: The store holds 8 bytes in arrival order. A host write to the data register (address 0) or an `eng_push` adds a byte. An `eng_pop` or a host read of address 0 removes the oldest byte. `eng_rdata` always shows the oldest byte. After reset the store is empty and `eng_full` is 0.
- R2: Bits [3:0] of a host read at address 1 give the current number of stored bytes. All other bits read 0.
- R3: A host write to address 1 whose bits [3:0] are zero empties the store at that clock edge, and it wins over any push or pop in the same cycle. A host write to address 1 with a nonzero value in bits [3:0] has no effect.
- R4: An `eng_start` pulse empties the store, unless bit 1 of the option register (address 5) is set, in which case the contents stay. The option register reads back in bit 1.
- R5: A push while the store is full is dropped. A pop while the store is empty does not change the fill count.
- R6: A host read of address 0 while the store is empty returns 0 and leaves the fill count at 0.
- R7: Bits [13:12] of the control register (address 2) hold the threshold code: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8. Only that field is stored and read back.
- R8: Status bit 2 becomes set at the edge after a cycle in which the fill count is at least the threshold. Status bit 3 becomes set at the edge after a cycle in which the free space is at least the threshold.
- R9: `eng_done`, `eng_rx_frame` and `eng_tx_frame` set status bits 0, 4 and 5 respectively. All status bits stay set until the host clears them.
- R10: A host write to the status register (address 3) clears every status bit written as 0 and keeps every bit written as 1. A set condition present in the same cycle still sets its bit.
- R11: The enable register (address 4) uses the same bit positions as the status register. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R12: If the host and the engine push in the same cycle, only the host byte is stored. If both sides pop in the same cycle, one byte leaves and both sides receive that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops at address 0) |
| host_addr | input | 3 | Host register index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| eng_push | input | 1 | Engine push strobe |
| eng_wdata | input | 8 | Engine push byte |
| eng_pop | input | 1 | Engine pop strobe |
| eng_rdata | output | 8 | Oldest stored byte |
| eng_full | output | 1 | Store holds 8 bytes |
| eng_empty | output | 1 | Store holds no byte |
| eng_start | input | 1 | Transfer start pulse (flush unless kept) |
| eng_done | input | 1 | Transfer finished event |
| eng_rx_frame | input | 1 | Frame received event |
| eng_tx_frame | input | 1 | Frame sent event |
| irq | output | 1 | OR of enabled status bits |

## Verification
A wrong read or write pointer shows up on the first pop after the bad push. The byte on `eng_rdata` or `host_rdata` is then out of order, which is why every popped byte is compared against a scoreboard. A wrong fill count is visible right away in the pointer register and in `eng_full`/`eng_empty`. A wrong count also moves the threshold flags one edge later. A status bit that is lost or stuck reaches `irq` in the same cycle once its enable is set. The flush and keep paths are checked by reading the fill count in the cycle after the pulse.

// File: rtl/fifo_ctl_pkg.sv
package fifo_ctl_pkg;

    typedef enum logic [2:0] {
        RA_DATA = 3'd0,
        RA_FILL = 3'd1,
        RA_CTRL = 3'd2,
        RA_STAT = 3'd3,
        RA_IEN  = 3'd4,
        RA_OPT  = 3'd5
    } reg_addr_e;

    localparam int ST_W     = 6;
    localparam int ST_DONE  = 0;
    localparam int ST_RXRDY = 2;
    localparam int ST_TXRDY = 3;
    localparam int ST_RXFRM = 4;
    localparam int ST_TXFRM = 5;

    localparam logic [ST_W-1:0] ST_MASK = 6'b111101;

    localparam int TRIG_LSB = 12;
    localparam int KEEP_BIT = 1;

    typedef struct packed {
        logic [1:0] code;
        logic       keep;
    } cfg_t;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t s_d, s_q;
    logic   do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.cnt != CW'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = push_data;
                s_d.wr          = step(s_q.wr);
            end
            if (do_pop) begin
                s_d.rd = step(s_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head  = s_q.mem[s_q.rd];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);

endmodule

// File: rtl/trig_status.sv
module trig_status
    import fifo_ctl_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = CW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   count,
    input  logic [1:0]      code,
    input  logic            stat_we,
    input  logic            ien_we,
    input  logic [ST_W-1:0] wdata,
    input  logic            ev_done,
    input  logic            ev_rxf,
    input  logic            ev_txf,
    output logic [ST_W-1:0] stat,
    output logic [ST_W-1:0] ien,
    output logic            irq
);

    typedef struct packed {
        logic [ST_W-1:0] stat;
        logic [ST_W-1:0] ien;
    } ts_t;

    ts_t             t_d, t_q;
    logic [LW-1:0]   lvl, fill_w, free_w;
    logic [ST_W-1:0] sets;

    always_comb begin
        lvl = LW'(1) << code;
        if (lvl > LW'(DEPTH)) begin
            lvl = LW'(DEPTH);
        end
        fill_w = LW'(count);
        free_w = LW'(DEPTH) - fill_w;

        sets           = '0;
        sets[ST_DONE]  = ev_done;
        sets[ST_RXRDY] = (fill_w >= lvl);
        sets[ST_TXRDY] = (free_w >= lvl);
        sets[ST_RXFRM] = ev_rxf;
        sets[ST_TXFRM] = ev_txf;

        t_d = t_q;
        if (stat_we) begin
            t_d.stat = t_q.stat & wdata;
        end
        t_d.stat = (t_d.stat | sets) & ST_MASK;
        if (ien_we) begin
            t_d.ien = wdata & ST_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign stat = t_q.stat;
    assign ien  = t_q.ien;
    assign irq  = |(t_q.stat & t_q.ien);

endmodule

// File: rtl/host_port.sv
module host_port
    import fifo_ctl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [2:0]      host_addr,
    input  logic [31:0]     host_wdata,
    input  logic [DW-1:0]   head,
    input  logic [CW-1:0]   count,
    input  cfg_t            cfg,
    input  logic [ST_W-1:0] stat,
    input  logic [ST_W-1:0] ien,
    output logic            h_push,
    output logic            h_pop,
    output logic            ptr_clear,
    output logic            ctrl_we,
    output logic            stat_we,
    output logic            ien_we,
    output logic            opt_we,
    output logic [31:0]     rdata
);

    always_comb begin
        h_push    = host_wr && (host_addr == RA_DATA);
        h_pop     = host_rd && (host_addr == RA_DATA);
        ptr_clear = host_wr && (host_addr == RA_FILL) && (host_wdata[3:0] == 4'd0);
        ctrl_we   = host_wr && (host_addr == RA_CTRL);
        stat_we   = host_wr && (host_addr == RA_STAT);
        ien_we    = host_wr && (host_addr == RA_IEN);
        opt_we    = host_wr && (host_addr == RA_OPT);

        rdata = '0;
        case (host_addr)
            RA_DATA: rdata = (count == '0) ? 32'd0 : 32'(head);
            RA_FILL: rdata = 32'(count);
            RA_CTRL: rdata[TRIG_LSB+1:TRIG_LSB] = cfg.code;
            RA_STAT: rdata = 32'(stat);
            RA_IEN:  rdata = 32'(ien);
            RA_OPT:  rdata[KEEP_BIT] = cfg.keep;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/byte_fifo_ctl.sv
module byte_fifo_ctl
    import fifo_ctl_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [2:0]    host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic          eng_push,
    input  logic [DW-1:0] eng_wdata,
    input  logic          eng_pop,
    output logic [DW-1:0] eng_rdata,
    output logic          eng_full,
    output logic          eng_empty,
    input  logic          eng_start,
    input  logic          eng_done,
    input  logic          eng_rx_frame,
    input  logic          eng_tx_frame,
    output logic          irq
);

    cfg_t            cfg_d, cfg_q;
    logic            h_push, h_pop, ptr_clear;
    logic            ctrl_we, stat_we, ien_we, opt_we;
    logic            f_push, f_pop, f_flush;
    logic [DW-1:0]   f_data, head;
    logic [CW-1:0]   fill_cnt;
    logic [ST_W-1:0] stat_q, ien_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_we) begin
            cfg_d.code = host_wdata[TRIG_LSB+1:TRIG_LSB];
        end
        if (opt_we) begin
            cfg_d.keep = host_wdata[KEEP_BIT];
        end
        f_push  = h_push || eng_push;
        f_data  = h_push ? host_wdata[DW-1:0] : eng_wdata;
        f_pop   = h_pop || eng_pop;
        f_flush = ptr_clear || (eng_start && !cfg_q.keep);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    host_port #(.DEPTH(DEPTH), .DW(DW)) u_host (
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .head      (head),
        .count     (fill_cnt),
        .cfg       (cfg_q),
        .stat      (stat_q),
        .ien       (ien_q),
        .h_push    (h_push),
        .h_pop     (h_pop),
        .ptr_clear (ptr_clear),
        .ctrl_we   (ctrl_we),
        .stat_we   (stat_we),
        .ien_we    (ien_we),
        .opt_we    (opt_we),
        .rdata     (host_rdata)
    );

    fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (f_flush),
        .push     (f_push),
        .push_data(f_data),
        .pop      (f_pop),
        .head     (head),
        .count    (fill_cnt),
        .full     (eng_full),
        .empty    (eng_empty)
    );

    trig_status #(.DEPTH(DEPTH)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (fill_cnt),
        .code   (cfg_q.code),
        .stat_we(stat_we),
        .ien_we (ien_we),
        .wdata  (host_wdata[ST_W-1:0]),
        .ev_done(eng_done),
        .ev_rxf (eng_rx_frame),
        .ev_txf (eng_tx_frame),
        .stat   (stat_q),
        .ien    (ien_q),
        .irq    (irq)
    );

    assign eng_rdata = head;

endmodule

// File: rtl/byte_fifo_ctl_checks.sv
module byte_fifo_ctl_checks #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic          host_rd,
    input logic [2:0]    host_addr,
    input logic [31:0]   host_wdata,
    input logic [31:0]   host_rdata,
    input logic          eng_pop,
    input logic          eng_full,
    input logic          eng_empty,
    input logic          eng_start,
    input logic          eng_done,
    input logic          irq,
    input logic [CW-1:0] fill,
    input logic [5:0]    stat,
    input logic [1:0]    lvl_code,
    input logic          keep
);

    logic stat_wr, ptr_zero, host_pop;
    assign stat_wr  = host_wr && (host_addr == 3'd3);
    assign ptr_zero = host_wr && (host_addr == 3'd1) && (host_wdata[3:0] == 4'd0);
    assign host_pop = host_rd && (host_addr == 3'd0);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) <= DEPTH); // R5
    AST_PTR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_zero |=> eng_empty); // R3
    AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && !keep) |=> eng_empty); // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && eng_empty) |-> (host_rdata == 32'd0)); // R6
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_full && !eng_pop && !host_pop && !eng_start && !ptr_zero) |=> eng_full); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && !stat_wr) |=> stat[0]); // R9
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> stat[0]); // R10
    AST_RX_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill) >= (1 << int'(lvl_code))) |=> stat[2]); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 6'd0) |-> !irq); // R11

endmodule

bind byte_fifo_ctl byte_fifo_ctl_checks #(.DEPTH(DEPTH)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .eng_pop   (eng_pop),
    .eng_full  (eng_full),
    .eng_empty (eng_empty),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .irq       (irq),
    .fill      (fill_cnt),
    .stat      (stat_q),
    .lvl_code  (cfg_q.code),
    .keep      (cfg_q.keep)
);

// File: tb/byte_fifo_ctl_bench.sv
module byte_fifo_ctl_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd;
    logic [2:0]  host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic        eng_push, eng_pop, eng_start, eng_done, eng_rx_frame, eng_tx_frame;
    logic [7:0]  eng_wdata, eng_rdata;
    logic        eng_full, eng_empty, irq;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [7:0]  sb[$];
    bit          keep_m = 1'b0;

    always #5 clk = ~clk;

    byte_fifo_ctl u_byte_fifo_ctl (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .eng_rdata(eng_rdata), .eng_full(eng_full), .eng_empty(eng_empty),
        .eng_start(eng_start), .eng_done(eng_done),
        .eng_rx_frame(eng_rx_frame), .eng_tx_frame(eng_tx_frame),
        .irq(irq)
    );

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        eng_push = 0; eng_wdata = 0; eng_pop = 0; eng_start = 0;
        eng_done = 0; eng_rx_frame = 0; eng_tx_frame = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        clear_in();
    endtask

    task automatic h_write(input logic [2:0] a, input logic [31:0] d);
        tick();
        host_wr = 1; host_addr = a; host_wdata = d;
        if (a == 3'd0 && sb.size() < DEPTH) sb.push_back(d[7:0]);
        if (a == 3'd1 && d[3:0] == 4'd0) sb.delete();
    endtask

    task automatic h_read(input logic [2:0] a, output logic [31:0] v);
        tick();
        host_rd = 1; host_addr = a;
        @(negedge clk);
        v = host_rdata;
    endtask

    task automatic read_expect(input logic [2:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        h_read(a, v);
        expect_eq(req, v, exp);
    endtask

    task automatic e_push(input logic [7:0] d);
        tick();
        eng_push = 1; eng_wdata = d;
        if (sb.size() < DEPTH) sb.push_back(d);
    endtask

    task automatic e_pop();
        tick();
        eng_pop = 1;
    endtask

    task automatic e_start();
        tick();
        eng_start = 1;
        if (!keep_m) sb.delete();
    endtask

    // Monitor: every byte that leaves the store is compared with the scoreboard
    always @(negedge clk) begin
        logic       hp, ep;
        logic [7:0] e;
        if (rst_n === 1'b1) begin
            hp = host_rd && (host_addr == 3'd0);
            ep = eng_pop;
            if (hp || ep) begin
                e = (sb.size() > 0) ? sb[0] : 8'h00;
                if (hp) expect_eq((sb.size() > 0) ? "R1 host data order" : "R6 empty read value",
                                  host_rdata, {24'h0, e});
                if (ep && sb.size() > 0) expect_eq("R1 engine data order", {24'h0, eng_rdata}, {24'h0, e});
                if (sb.size() > 0) void'(sb.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0;
        clear_in();
        host_addr = 3'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_eq("R1 reset empty", {31'h0, eng_empty}, 32'd1);
        expect_eq("R1 reset full", {31'h0, eng_full}, 32'd0);
        expect_eq("R11 reset irq", {31'h0, irq}, 32'd0);
        expect_eq("R9 reset status", host_rdata, 32'd0);
        @(posedge clk);
        #2;
        rst_n = 1;

        read_expect(3'd1, 32'd0, "R2 fill after reset");

        // R7 threshold field
        h_write(3'd2, 32'hFFFF_FFFF);
        read_expect(3'd2, 32'h0000_3000, "R7 only field stored");
        h_write(3'd2, 32'h0000_2000);
        read_expect(3'd2, 32'h0000_2000, "R7 code 2 readback");
        h_write(3'd2, 32'h0000_3000);

        // R1/R2 host in, engine out
        h_write(3'd0, 32'hA1);
        h_write(3'd0, 32'hA2);
        h_write(3'd0, 32'hA3);
        read_expect(3'd1, 32'd3, "R2 fill count three");
        e_pop(); e_pop(); e_pop();
        read_expect(3'd1, 32'd0, "R1 drained");

        // R5 full drop, wrapped pointers
        for (int i = 0; i < 8; i++) e_push(8'h10 + 8'(i));
        e_push(8'h99);
        read_expect(3'd1, 32'd8, "R5 push when full dropped");
        expect_eq("R5 full flag", {31'h0, eng_full}, 32'd1);
        read_expect(3'd3, 32'h0C, "R8 read and write ready at level 8");
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            h_read(3'd0, v);
        end
        begin
            logic [31:0] v;
            h_read(3'd0, v);
        end
        read_expect(3'd1, 32'd0, "R6 fill stays zero after empty read");
        e_pop();
        read_expect(3'd1, 32'd0, "R5 pop when empty");

        // R10/R9 status clear and events
        for (int i = 0; i < 4; i++) h_write(3'd0, 32'hB0 + i);
        h_write(3'd3, 32'h0);
        read_expect(3'd3, 32'h00, "R10 write zero clears all");
        tick(); eng_done = 1;
        tick(); eng_tx_frame = 1;
        read_expect(3'd3, 32'h21, "R9 event flags sticky");
        tick(); eng_rx_frame = 1;
        read_expect(3'd3, 32'h31, "R9 frame received flag");
        h_write(3'd3, 32'h20);
        read_expect(3'd3, 32'h20, "R10 per-bit clear");

        // R11 interrupt masking
        h_write(3'd4, 32'h01);
        read_expect(3'd4, 32'h01, "R11 enable readback");
        expect_eq("R11 masked irq", {31'h0, irq}, 32'd0);
        h_write(3'd4, 32'h20);
        read_expect(3'd4, 32'h20, "R11 enable readback 2");
        expect_eq("R11 enabled irq", {31'h0, irq}, 32'd1);
        h_write(3'd4, 32'h00);

        // R8 at level 4 with 4 stored
        h_write(3'd2, 32'h0000_2000);
        h_write(3'd3, 32'h0);
        read_expect(3'd3, 32'h0C, "R8 both ready at level 4");

        // R3 pointer writes
        h_write(3'd1, 32'd5);
        read_expect(3'd1, 32'd4, "R3 nonzero pointer write ignored");
        h_write(3'd1, 32'd0);
        read_expect(3'd1, 32'd0, "R3 pointer write empties");

        // R4 start flush and keep
        h_write(3'd0, 32'hC1);
        h_write(3'd0, 32'hC2);
        e_start();
        read_expect(3'd1, 32'd0, "R4 start flushes");
        h_write(3'd5, 32'd2);
        keep_m = 1'b1;
        read_expect(3'd5, 32'd2, "R4 option readback");
        h_write(3'd0, 32'hD1);
        h_write(3'd0, 32'hD2);
        e_start();
        read_expect(3'd1, 32'd2, "R4 start keeps contents");
        e_pop(); e_pop();

        // R12 simultaneous pushes
        tick();
        host_wr = 1; host_addr = 3'd0; host_wdata = 32'hE1;
        eng_push = 1; eng_wdata = 8'hE9;
        sb.push_back(8'hE1);
        read_expect(3'd1, 32'd1, "R12 only host byte stored");
        e_pop();

        // R12 simultaneous pops
        h_write(3'd0, 32'hF1);
        h_write(3'd0, 32'hF2);
        tick();
        eng_pop = 1; host_rd = 1; host_addr = 3'd0;
        read_expect(3'd1, 32'd1, "R12 dual pop removes one");
        e_pop();

        // R3 flush wins over push
        h_write(3'd0, 32'h77);
        tick();
        host_wr = 1; host_addr = 3'd1; host_wdata = 32'd0;
        eng_push = 1; eng_wdata = 8'h55;
        sb.delete();
        read_expect(3'd1, 32'd0, "R3 flush beats push");

        tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule